// File: doc/BRIEF.md
# SPI Burst Memory Access Target

This block is an SPI target (mode 0, most significant bit first, 32-bit words) that lets a host read or write an internal word-addressed message RAM. Every chip-select window opens with a single header word. The header holds an opcode, a start word address and a word count. The block then moves that many 32-bit data words to or from consecutive RAM locations. A whole CAN frame buffer element can therefore be stored or fetched with one header and one burst, and the host never sends an address per word.

One SPI bus serves both directions, so each transaction is either a write or a read. The RAM has a single port, and reads and writes never reach it in the same cycle. For reads, the first data word is fetched as soon as the header's last bit is sampled, so data appears on MISO in the very next word slot and no dummy word is needed. SCLK, chip select and MOSI are sampled with the system clock, which must be fast enough that each SCLK phase lasts at least four system clock cycles.

Top module: `spi_burst_mem`

## Requirements
- R1: The header word is decoded as opcode in bits 31:24 (0x61 writes, 0x41 reads), word address in bits 23:8 and word count in bits 7:0. Only the low ADDR_W address bits select a RAM word; the upper address bits are ignored.
- R2: In a write, data word k of the burst is stored at start address plus k.
- R3: In a read, the word at start address plus k is shifted out during data word slot k. Slot 0 is the word that follows the header directly, with no dummy word.
- R4: A word count of 0 in the header means a burst of 256 words.
- R5: The burst address wraps from the top RAM word (2^ADDR_W - 1) to word 0.
- R6: Words clocked after the burst length has been reached have no effect. In a write they do not change the RAM. In a read, MISO returns all zeros for them.
- R7: A header with any other opcode makes the block ignore the rest of the transaction. No RAM word changes, and MISO stays 0.
- R8: When chip select goes high, any burst in progress stops and a partly shifted word is discarded. This also covers the case where the release arrives in the same system cycle as the 32nd SCLK rising edge of a word.
- R9: MISO is 0 after reset, while chip select is high, and for every bit of the header word.
- R10: MOSI is sampled on SCLK rising edges and MISO changes only after SCLK falling edges, in both cases most significant bit first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; samples every SPI signal |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sclk | input | 1 | SPI serial clock from the host, idle low |
| spi_cs_n | input | 1 | Active-low chip select framing one transaction |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host, driven low when idle |

## Verification
The 32nd SCLK rising edge of a word completes that word and triggers a RAM write or prefetch. A chip-select release ends the transaction. Both events can land in the same system cycle. The bench provokes this by raising SCLK and chip select on the same clock edge for the last bit of a single-word write. It then judges the outcome by reading the target word back in a later transaction and expecting the value it held beforehand. The bench also aborts a burst in mid-word, after one full data word, and expects the completed word to be stored and the following word to be untouched.

// File: rtl/spimem_pkg.sv
// Shared definitions for the SPI burst memory target: header layout,
// opcodes and controller states. Assumes 32-bit SPI words.
package spimem_pkg;

    localparam int unsigned HDR_W = 32;

    localparam logic [7:0] OP_WRITE = 8'h61;
    localparam logic [7:0] OP_READ  = 8'h41;

    typedef struct packed {
        logic [7:0]  op;
        logic [15:0] addr;
        logic [7:0]  len;
    } spimem_hdr_t;

    typedef enum logic [1:0] {
        ST_HDR,
        ST_WR,
        ST_RD,
        ST_SKIP
    } spimem_state_e;

endpackage

// File: rtl/spimem_sync.sv
// Multi-stage synchronizer for a vector of asynchronous single-bit inputs.
// Each bit has its own flop chain with its own reset value. Assumes the
// inputs are slow compared with clk.
module spimem_sync #(
    parameter int unsigned         WIDTH   = 3,
    parameter int unsigned         STAGES  = 2,
    parameter logic [WIDTH-1:0]    RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain;

        // Shift the raw input through the chain of this bit.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chain <= {STAGES{RST_VAL[b]}};
            end else begin
                chain <= {chain[STAGES-2:0], din[b]};
            end
        end

        assign dout[b] = chain[STAGES-1];
    end

endmodule

// File: rtl/spimem_shifter.sv
// SPI mode 0 word shifter. It detects SCLK edges on the synchronized
// signals, assembles received words MSB first and pulses word_done one
// cycle after the last rising edge of a word. At the first falling edge of
// every word slot it loads tx_word and then shifts it out MSB first.
// A high chip select clears all state, so partial words are lost.
module spimem_shifter #(
    parameter int unsigned WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s,
    input  logic              cs_n_s,
    input  logic              mosi_s,
    input  logic [WORD_W-1:0] tx_word,
    output logic [WORD_W-1:0] rx_word,
    output logic              word_done,
    output logic              miso
);

    localparam int unsigned           CNT_W = $clog2(WORD_W);
    localparam logic [CNT_W-1:0]      LAST  = CNT_W'(WORD_W - 1);

    logic              sclk_d;
    logic              rise;
    logic              fall;
    logic [CNT_W-1:0]  bit_cnt;
    logic [WORD_W-1:0] rx_sh;
    logic [WORD_W-1:0] tx_sh;

    assign rise = sclk_s & ~sclk_d & ~cs_n_s;
    assign fall = ~sclk_s & sclk_d & ~cs_n_s;

    // Delayed SCLK used for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_d <= 1'b0;
        else        sclk_d <= sclk_s;
    end

    // Receive path: sample MOSI on rising edges and flag completed words.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_n_s) begin
            bit_cnt   <= '0;
            rx_sh     <= '0;
            word_done <= 1'b0;
        end else begin
            word_done <= 1'b0;
            if (rise) begin
                rx_sh   <= {rx_sh[WORD_W-2:0], mosi_s};
                bit_cnt <= (bit_cnt == LAST) ? '0 : bit_cnt + 1'b1;
                if (bit_cnt == LAST) word_done <= 1'b1;
            end
        end
    end

    // Capture the completed word for the controller.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_word <= '0;
        end else if (rise && bit_cnt == LAST) begin
            rx_word <= {rx_sh[WORD_W-2:0], mosi_s};
        end
    end

    // Transmit path: update MISO on falling edges, load a new word at each slot start.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_n_s) begin
            miso  <= 1'b0;
            tx_sh <= '0;
        end else if (fall) begin
            if (bit_cnt == '0) begin
                miso  <= tx_word[WORD_W-1];
                tx_sh <= {tx_word[WORD_W-2:0], 1'b0};
            end else begin
                miso  <= tx_sh[WORD_W-1];
                tx_sh <= {tx_sh[WORD_W-2:0], 1'b0};
            end
        end
    end

    assert_idle_miso_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_s |=> !miso);

    assert_miso_on_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!fall && !cs_n_s) |=> $stable(miso));

endmodule

// File: rtl/spimem_ctrl.sv
// Transaction controller. It decodes the header word, keeps the burst
// address and the count of remaining words, and issues RAM reads and
// writes at word boundaries. A read of the next word is issued in the
// cycle its predecessor completes, so the data is ready before the next
// slot starts. Assumes WORD_W equals the header width.
module spimem_ctrl
    import spimem_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned WORD_W = 32,
    parameter int unsigned LEN_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_s,
    input  logic              word_done,
    input  logic [WORD_W-1:0] rx_word,
    output logic              ram_rd,
    output logic              ram_wr,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [WORD_W-1:0] ram_wdata,
    output logic              tx_zero
);

    localparam int unsigned      CNT_W     = LEN_W + 1;
    localparam logic [CNT_W-1:0] BURST_MAX = CNT_W'(1 << LEN_W);

    spimem_state_e     state;
    spimem_hdr_t       hdr;
    logic [ADDR_W-1:0] hdr_addr;
    logic [CNT_W-1:0]  hdr_cnt;
    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  left_q;

    assign hdr      = spimem_hdr_t'(rx_word[HDR_W-1:0]);
    assign hdr_addr = hdr.addr[ADDR_W-1:0];
    assign hdr_cnt  = (hdr.len == '0) ? BURST_MAX : CNT_W'(hdr.len);

    // RAM request decode for the word that has just completed.
    always_comb begin
        ram_rd    = word_done && ((state == ST_HDR && hdr.op == OP_READ) ||
                                  (state == ST_RD && left_q > 1));
        ram_wr    = word_done && state == ST_WR && left_q != '0;
        ram_addr  = (state == ST_HDR) ? hdr_addr : addr_q;
        ram_wdata = rx_word;
    end

    // Burst state, address auto-increment and remaining-word count.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_n_s) begin
            state   <= ST_HDR;
            addr_q  <= '0;
            left_q  <= '0;
            tx_zero <= 1'b1;
        end else if (word_done) begin
            unique case (state)
                ST_HDR: begin
                    if (hdr.op == OP_WRITE) begin
                        state  <= ST_WR;
                        addr_q <= hdr_addr;
                        left_q <= hdr_cnt;
                    end else if (hdr.op == OP_READ) begin
                        state   <= ST_RD;
                        addr_q  <= hdr_addr + 1'b1;
                        left_q  <= hdr_cnt;
                        tx_zero <= 1'b0;
                    end else begin
                        state <= ST_SKIP;
                    end
                end
                ST_WR: begin
                    if (left_q != '0) begin
                        addr_q <= addr_q + 1'b1;
                        left_q <= left_q - 1'b1;
                    end
                end
                ST_RD: begin
                    if (left_q != '0) left_q <= left_q - 1'b1;
                    if (left_q > 1) addr_q <= addr_q + 1'b1;
                    else            tx_zero <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    assert_skip_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SKIP) |-> (!ram_rd && !ram_wr && tx_zero));

    assert_write_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WR && left_q == '0) |-> !ram_wr);

    assert_read_tail_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RD && left_q == '0) |-> tx_zero);

endmodule

// File: rtl/spimem_ram.sv
// Single-port message RAM, word addressed, with a registered read. The
// read data register holds its value until the next read. Assumes the
// caller never asks for a read and a write in the same cycle.
module spimem_ram #(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata
);

    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] mem [DEPTH];

    // Storage write port.
    always_ff @(posedge clk) begin
        if (wr_en) mem[addr] <= wdata;
    end

    // Registered read port.
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= mem[addr];
    end

    assert_no_rw_overlap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && wr_en));

endmodule

// File: rtl/spi_burst_mem.sv
// SPI burst memory target, top level. It synchronizes the SPI pins,
// shifts 32-bit words, decodes the header and moves burst data to or
// from the internal RAM. Each SCLK phase must last at least four clk
// cycles.
module spi_burst_mem #(
    parameter int unsigned ADDR_W      = 8,
    parameter int unsigned WORD_W      = 32,
    parameter int unsigned LEN_W       = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic spi_sclk,
    input  logic spi_cs_n,
    input  logic spi_mosi,
    output logic spi_miso
);

    localparam int unsigned PIN_N = 3;

    logic [PIN_N-1:0]  pins_s;
    logic              sclk_s;
    logic              cs_n_s;
    logic              mosi_s;
    logic [WORD_W-1:0] rx_word;
    logic              word_done;
    logic [WORD_W-1:0] tx_word;
    logic              tx_zero;
    logic              ram_rd;
    logic              ram_wr;
    logic [ADDR_W-1:0] ram_addr;
    logic [WORD_W-1:0] ram_wdata;
    logic [WORD_W-1:0] ram_rdata;

    spimem_sync #(
        .WIDTH   (PIN_N),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b010)
    ) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({spi_mosi, spi_cs_n, spi_sclk}),
        .dout  (pins_s)
    );

    assign sclk_s = pins_s[0];
    assign cs_n_s = pins_s[1];
    assign mosi_s = pins_s[2];

    assign tx_word = tx_zero ? '0 : ram_rdata;

    spimem_shifter #(
        .WORD_W (WORD_W)
    ) shifter_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_s    (sclk_s),
        .cs_n_s    (cs_n_s),
        .mosi_s    (mosi_s),
        .tx_word   (tx_word),
        .rx_word   (rx_word),
        .word_done (word_done),
        .miso      (spi_miso)
    );

    spimem_ctrl #(
        .ADDR_W (ADDR_W),
        .WORD_W (WORD_W),
        .LEN_W  (LEN_W)
    ) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n_s    (cs_n_s),
        .word_done (word_done),
        .rx_word   (rx_word),
        .ram_rd    (ram_rd),
        .ram_wr    (ram_wr),
        .ram_addr  (ram_addr),
        .ram_wdata (ram_wdata),
        .tx_zero   (tx_zero)
    );

    spimem_ram #(
        .ADDR_W (ADDR_W),
        .WORD_W (WORD_W)
    ) ram_i (
        .clk   (clk),
        .rst_n (rst_n),
        .rd_en (ram_rd),
        .wr_en (ram_wr),
        .addr  (ram_addr),
        .wdata (ram_wdata),
        .rdata (ram_rdata)
    );

    assert_write_while_selected_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ram_wr |-> !cs_n_s);

endmodule

// File: tb/spi_burst_mem_tb_top.sv
`timescale 1ns/1ps
module spi_burst_mem_tb_top;

    localparam int HALF = 4;
    localparam int NVEC = 5;
    // Vector fields: start address [39:24], header count [23:16], data seed [15:0]
    localparam logic [39:0] VEC [NVEC] = '{
        {16'h0010, 8'd4,  16'h1111},
        {16'h0080, 8'd1,  16'h2222},
        {16'h00FE, 8'd4,  16'h3333},
        {16'h1234, 8'd3,  16'h4444},
        {16'h00A0, 8'd18, 16'h5555}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic spi_sclk = 1'b0;
    logic spi_cs_n = 1'b1;
    logic spi_mosi = 1'b0;
    logic spi_miso;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] model [256];
    bit          known [256];

    always #2.5 clk = ~clk;

    spi_burst_mem dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .spi_sclk (spi_sclk),
        .spi_cs_n (spi_cs_n),
        .spi_mosi (spi_mosi),
        .spi_miso (spi_miso)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    function automatic logic [31:0] pat(input logic [15:0] seed, input int i);
        return {seed, 8'(i), ~8'(i)};
    endfunction

    task automatic spi_bits(input logic [31:0] tx, input int n, output logic [31:0] rx);
        rx = '0;
        for (int i = 31; i > 31 - n; i--) begin
            spi_mosi = tx[i];
            repeat (HALF) @(negedge clk);
            rx[i] = spi_miso;
            spi_sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            spi_sclk = 1'b0;
        end
    endtask

    task automatic select();
        @(negedge clk);
        spi_cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic release_cs();
        repeat (HALF) @(negedge clk);
        spi_cs_n = 1'b1;
        repeat (3 * HALF) @(negedge clk);
    endtask

    task automatic do_write(input logic [15:0] addr, input logic [7:0] len,
                            input logic [15:0] seed, input int nwords);
        logic [31:0] rx;
        logic [31:0] d;
        int eff = (len == 0) ? 256 : int'(len);
        select();
        spi_bits({8'h61, addr, len}, 32, rx);
        check("R9 header miso", rx, 32'h0);
        for (int i = 0; i < nwords; i++) begin
            d = (i < eff) ? pat(seed, i) : (pat(seed, i) ^ 32'hFFFF_0000);
            spi_bits(d, 32, rx);
            if (i < eff) begin
                model[(int'(addr) + i) % 256] = d;
                known[(int'(addr) + i) % 256] = 1'b1;
            end
        end
        release_cs();
    endtask

    task automatic do_read(input logic [15:0] addr, input logic [7:0] len,
                           input int extra, input string req);
        logic [31:0] rx;
        int eff = (len == 0) ? 256 : int'(len);
        int a;
        select();
        spi_bits({8'h41, addr, len}, 32, rx);
        check("R9 header miso", rx, 32'h0);
        for (int i = 0; i < eff; i++) begin
            spi_bits(32'h0, 32, rx);
            a = (int'(addr) + i) % 256;
            if (known[a]) check(req, rx, model[a]);
        end
        for (int i = 0; i < extra; i++) begin
            spi_bits(32'h0, 32, rx);
            check("R6 read past burst", rx, 32'h0);
        end
        release_cs();
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] rx;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R9 miso after reset", {31'h0, spi_miso}, 32'h0);

        // Table walk: write each burst, then read it back with one extra slot.
        for (int v = 0; v < NVEC; v++) begin
            do_write(VEC[v][39:24], VEC[v][23:16], VEC[v][15:0], int'(VEC[v][23:16]));
            do_read(VEC[v][39:24], VEC[v][23:16], 1, "R1 R2 R3 R5 R10 readback");
        end

        // R7: unknown opcode leaves the RAM alone and MISO at zero.
        do_write(16'h0060, 8'd1, 16'h6666, 1);
        select();
        spi_bits({8'h77, 16'h0060, 8'd1}, 32, rx);
        spi_bits(32'hDEAD_BEEF, 32, rx);
        check("R7 miso during ignored word", rx, 32'h0);
        spi_bits(32'h1234_5678, 32, rx);
        check("R7 miso during ignored word", rx, 32'h0);
        release_cs();
        do_read(16'h0060, 8'd1, 0, "R7 ram unchanged");

        // R6: words beyond the count are dropped in a write.
        do_write(16'h0070, 8'd2, 16'h7070, 4);
        do_read(16'h0070, 8'd3, 0, "R6 write past burst");

        // R8: abort in mid-word after one full data word.
        do_write(16'h0040, 8'd2, 16'h7777, 2);
        select();
        spi_bits({8'h61, 16'h0040, 8'd3}, 32, rx);
        spi_bits(pat(16'h8888, 0), 32, rx);
        model[8'h40] = pat(16'h8888, 0);
        spi_bits(32'hFFFF_FFFF, 15, rx);
        release_cs();
        do_read(16'h0040, 8'd2, 0, "R8 partial word dropped");

        // R8: release lands with the 32nd rising edge of the only word.
        do_write(16'h0050, 8'd1, 16'h9999, 1);
        select();
        spi_bits({8'h61, 16'h0050, 8'd1}, 32, rx);
        spi_bits(32'hCAFE_F00D, 31, rx);
        spi_mosi = 1'b1;
        repeat (HALF) @(negedge clk);
        spi_sclk = 1'b1;
        spi_cs_n = 1'b1;
        repeat (HALF) @(negedge clk);
        spi_sclk = 1'b0;
        repeat (3 * HALF) @(negedge clk);
        do_read(16'h0050, 8'd1, 0, "R8 same-cycle release");

        // R4: a count of 0 moves 256 words; a 257th word is dropped (R6).
        do_write(16'h0020, 8'd0, 16'hABCD, 257);
        do_read(16'h001F, 8'd3, 0, "R4 R6 full 256-word burst");

        check("R9 miso idle at end", {31'h0, spi_miso}, 32'h0);
        summary();
        $finish;
    end

endmodule